// File: doc/BRIEF.md
# CCD Horizontal Readout Timing Generator

This block produces the fast per-pixel waveforms that move charge out of an interline-transfer CCD's horizontal register and strobe a correlated double sampler. It runs from one master clock at four ticks per pixel. Inside each pixel the two complementary horizontal clocks, the reset-gate pulse and the clamp and sample strobes sit at fixed tick offsets. The sample strobe wraps into the first tick of the following pixel.

Next to the waveforms, the block tracks the column and line of every pixel slot. It tags each slot as dummy, optical black, active or blanking. It raises line-start and field-start strobes, counts fields, and fires one substrate shutter pulse per field on a programmable line. The leading and trailing optical-black row counts and the shutter line are inputs. They are captured only while the block is disabled or at the wrap to a new field, so a change never tears a field in progress.

Top module: `ccd_htiming_gen`

## Requirements
- R1: The output sequence is aligned to the first rising edge of `h1_o` after enable. Within each four-cycle pixel window, `h1_o` is high in ticks 0 and 1 and low in ticks 2 and 3. `h2_o` is always its complement while enabled.
- R2: `rg_o` is high in ticks 0–1 and `ds1_o` is high in ticks 1–2. `ds2_o` is high in tick 3 and in tick 0 of the following pixel, but not in tick 0 of the first pixel after enable. `ds1_o` and `ds2_o` are never high together.
- R3: Along a line, column slots run in this order: `DUMMY_COLS` dummy, `OB_LEAD` optical black, `ACT_COLS` active, `OB_TRAIL` optical black, then `HBLANK` blanking slots. `region_o` encodes 0 as none, 1 as dummy, 2 as optical black and 3 as active. Blanking slots read as none while the horizontal clocks keep toggling.
- R4: Along a field, lines run in this order: `DUMMY_ROWS` dummy, captured leading-black count, `ACT_ROWS` active, captured trailing-black count. Outside blanking, a slot is dummy if its column or line is dummy. Otherwise it is optical black if either is optical black. Otherwise it is active.
- R5: `line_start_o` is high for the whole pixel window of column 0. `field_start_o` is high for the pixel window of column 0 on line 0.
- R6: `shutter_o` is high for the pixel window of column 0 on the line equal to the captured shutter line. This gives exactly one pulse per field when that line exists.
- R7: `ob_top_i`, `ob_bot_i` and `shut_line_i` are captured only while `en_i` is low or on the last tick of a field. A change during a field first takes effect in the next field.
- R8: When `en_i` is sampled low, every pulse, flag, strobe, `col_o` and `line_o` reads 0 after that edge. The edge that first samples `en_i` high restarts the block at tick 0 of column 0, line 0.
- R9: `col_o` and `line_o` give the column and line of the current pixel. `field_o` counts completed fields modulo 2^`FIELD_W`, holds its value across a disable, and is cleared only by reset.
- R10: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, four ticks per pixel |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Synchronous run enable |
| ob_top_i | input | OB_W | Leading optical-black line count |
| ob_bot_i | input | OB_W | Trailing optical-black line count |
| shut_line_i | input | ROW_W | Line on which the shutter pulse fires |
| h1_o | output | 1 | Horizontal register clock 1 |
| h2_o | output | 1 | Horizontal register clock 2 |
| rg_o | output | 1 | Reset-gate pulse |
| ds1_o | output | 1 | Clamp strobe, reset level |
| ds2_o | output | 1 | Sample strobe, signal level |
| region_o | output | 2 | Slot class: 0 none, 1 dummy, 2 black, 3 active |
| line_start_o | output | 1 | First slot of a line |
| field_start_o | output | 1 | First slot of a field |
| shutter_o | output | 1 | Substrate shutter pulse |
| col_o | output | COL_W | Current column |
| line_o | output | ROW_W | Current line |
| field_o | output | FIELD_W | Completed field count |

## Verification
The hardest case to reach is a configuration change that lands in the middle of a field. The new black counts and shutter line must stay invisible until the field wraps, and then apply to the whole of the next field. The stimulus changes all three inputs partway through a running field and lets several complete fields pass. A reference model compares every slot's class, strobe and shutter position cycle by cycle. The stimulus also drops the enable in the middle of a line, changes the shutter line while the block is disabled, and re-enables it. This exercises the restart alignment and the suppressed first sample strobe.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;
  localparam int TICKS = 4;

  typedef enum logic [1:0] {
    REG_NONE  = 2'd0,
    REG_DUMMY = 2'd1,
    REG_OB    = 2'd2,
    REG_ACT   = 2'd3
  } region_e;

  function automatic region_e merge_region(region_e c, region_e r);
    if (c == REG_NONE) return REG_NONE;
    if (c == REG_DUMMY || r == REG_DUMMY) return REG_DUMMY;
    if (c == REG_OB || r == REG_OB) return REG_OB;
    return REG_ACT;
  endfunction
endpackage

// File: rtl/ccd_tick_gen.sv
module ccd_tick_gen
  import ccd_tg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic px_end_o,
  output logic h1_o,
  output logic rg_o,
  output logic ds1_o,
  output logic ds2_o
);
  localparam int TW = $clog2(TICKS);
  localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

  logic [TW-1:0] tick_q;
  logic          started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q    <= '0;
      started_q <= 1'b0;
    end else if (!en_i) begin
      tick_q    <= '0;
      started_q <= 1'b0;
    end else begin
      tick_q <= (tick_q == LAST) ? '0 : tick_q + 1'b1;
      if (tick_q == LAST) started_q <= 1'b1;
    end
  end

  assign px_end_o = en_i && (tick_q == LAST);
  assign h1_o     = (tick_q < TW'(2));
  assign rg_o     = (tick_q < TW'(2));
  assign ds1_o    = (tick_q == TW'(1)) || (tick_q == TW'(2));
  // sample strobe wraps into tick 0 of the next pixel, none before the first pixel
  assign ds2_o    = (tick_q == LAST) || (tick_q == '0 && started_q);
endmodule

// File: rtl/ccd_col_ctr.sv
module ccd_col_ctr
  import ccd_tg_pkg::*;
#(
  parameter int DUMMY_COLS = 1,
  parameter int OB_LEAD    = 4,
  parameter int ACT_COLS   = 962,
  parameter int OB_TRAIL   = 41,
  parameter int HBLANK     = 16,
  parameter int COL_W      = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             px_end_i,
  output logic [COL_W-1:0] col_o,
  output logic             line_end_o,
  output region_e          region_o
);
  localparam int C_OB0  = DUMMY_COLS;
  localparam int C_ACT0 = C_OB0 + OB_LEAD;
  localparam int C_OB1  = C_ACT0 + ACT_COLS;
  localparam int C_BLK  = C_OB1 + OB_TRAIL;
  localparam int C_TOT  = C_BLK + HBLANK;

  logic [COL_W-1:0] col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        col_q <= '0;
    else if (!en_i)     col_q <= '0;
    else if (px_end_i)  col_q <= (col_q == COL_W'(C_TOT - 1)) ? '0 : col_q + 1'b1;
  end

  assign col_o      = col_q;
  assign line_end_o = px_end_i && (col_q == COL_W'(C_TOT - 1));

  always_comb begin
    if (col_q < COL_W'(C_OB0))       region_o = REG_DUMMY;
    else if (col_q < COL_W'(C_ACT0)) region_o = REG_OB;
    else if (col_q < COL_W'(C_OB1))  region_o = REG_ACT;
    else if (col_q < COL_W'(C_BLK))  region_o = REG_OB;
    else                             region_o = REG_NONE;
  end
endmodule

// File: rtl/ccd_row_ctr.sv
module ccd_row_ctr
  import ccd_tg_pkg::*;
#(
  parameter int DUMMY_ROWS = 2,
  parameter int ACT_ROWS   = 654,
  parameter int OB_W       = 4,
  parameter int ROW_W      = 10,
  parameter int FIELD_W    = 8,
  parameter int OB_TOP_RST = 8,
  parameter int OB_BOT_RST = 2,
  parameter int SHUT_RST   = 100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               line_end_i,
  input  logic [OB_W-1:0]    ob_top_i,
  input  logic [OB_W-1:0]    ob_bot_i,
  input  logic [ROW_W-1:0]   shut_line_i,
  output logic [ROW_W-1:0]   row_o,
  output logic [FIELD_W-1:0] field_o,
  output logic               shut_hit_o,
  output region_e            region_o
);
  localparam int RW1 = ROW_W + 1;

  logic [ROW_W-1:0]   row_q, shut_q;
  logic [OB_W-1:0]    obt_q, obb_q;
  logic [FIELD_W-1:0] field_q;
  logic [RW1-1:0]     b_ob, b_act, b_last;
  logic               field_end;

  assign b_ob      = RW1'(DUMMY_ROWS) + RW1'(obt_q);
  assign b_act     = b_ob + RW1'(ACT_ROWS);
  assign b_last    = b_act + RW1'(obb_q) - 1'b1;
  assign field_end = line_end_i && (RW1'(row_q) == b_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q   <= '0;
      field_q <= '0;
      obt_q   <= OB_W'(OB_TOP_RST);
      obb_q   <= OB_W'(OB_BOT_RST);
      shut_q  <= ROW_W'(SHUT_RST);
    end else if (!en_i || field_end) begin
      row_q  <= '0;
      obt_q  <= ob_top_i;
      obb_q  <= ob_bot_i;
      shut_q <= shut_line_i;
      if (field_end) field_q <= field_q + 1'b1;
    end else if (line_end_i) begin
      row_q <= row_q + 1'b1;
    end
  end

  assign row_o      = row_q;
  assign field_o    = field_q;
  assign shut_hit_o = (row_q == shut_q);

  always_comb begin
    if (RW1'(row_q) < RW1'(DUMMY_ROWS)) region_o = REG_DUMMY;
    else if (RW1'(row_q) < b_ob)        region_o = REG_OB;
    else if (RW1'(row_q) < b_act)       region_o = REG_ACT;
    else                                region_o = REG_OB;
  end

  a_r4_row_in_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    RW1'(row_q) <= b_last);
  a_r9_field_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !field_end |=> $stable(field_q));
endmodule

// File: rtl/ccd_htiming_gen.sv
module ccd_htiming_gen
  import ccd_tg_pkg::*;
#(
  parameter int DUMMY_COLS = 1,
  parameter int OB_LEAD    = 4,
  parameter int ACT_COLS   = 962,
  parameter int OB_TRAIL   = 41,
  parameter int HBLANK     = 16,
  parameter int DUMMY_ROWS = 2,
  parameter int ACT_ROWS   = 654,
  parameter int OB_W       = 4,
  parameter int FIELD_W    = 8,
  parameter int OB_TOP_RST = 8,
  parameter int OB_BOT_RST = 2,
  parameter int SHUT_RST   = 100,
  parameter int COL_W = $clog2(DUMMY_COLS + OB_LEAD + ACT_COLS + OB_TRAIL + HBLANK),
  parameter int ROW_W = $clog2(DUMMY_ROWS + ACT_ROWS + 2 * ((1 << OB_W) - 1))
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [OB_W-1:0]    ob_top_i,
  input  logic [OB_W-1:0]    ob_bot_i,
  input  logic [ROW_W-1:0]   shut_line_i,
  output logic               h1_o,
  output logic               h2_o,
  output logic               rg_o,
  output logic               ds1_o,
  output logic               ds2_o,
  output logic [1:0]         region_o,
  output logic               line_start_o,
  output logic               field_start_o,
  output logic               shutter_o,
  output logic [COL_W-1:0]   col_o,
  output logic [ROW_W-1:0]   line_o,
  output logic [FIELD_W-1:0] field_o
);
  logic               px_end, line_end, shut_hit;
  logic               h1_c, rg_c, ds1_c, ds2_c;
  logic [COL_W-1:0]   col;
  logic [ROW_W-1:0]   row;
  logic [FIELD_W-1:0] field;
  region_e            col_rgn, row_rgn;
  logic               first_col;

  ccd_tick_gen u_tick (
    .clk_i, .rst_ni, .en_i,
    .px_end_o(px_end), .h1_o(h1_c), .rg_o(rg_c), .ds1_o(ds1_c), .ds2_o(ds2_c)
  );

  ccd_col_ctr #(
    .DUMMY_COLS(DUMMY_COLS), .OB_LEAD(OB_LEAD), .ACT_COLS(ACT_COLS),
    .OB_TRAIL(OB_TRAIL), .HBLANK(HBLANK), .COL_W(COL_W)
  ) u_col (
    .clk_i, .rst_ni, .en_i, .px_end_i(px_end),
    .col_o(col), .line_end_o(line_end), .region_o(col_rgn)
  );

  ccd_row_ctr #(
    .DUMMY_ROWS(DUMMY_ROWS), .ACT_ROWS(ACT_ROWS), .OB_W(OB_W), .ROW_W(ROW_W),
    .FIELD_W(FIELD_W), .OB_TOP_RST(OB_TOP_RST), .OB_BOT_RST(OB_BOT_RST),
    .SHUT_RST(SHUT_RST)
  ) u_row (
    .clk_i, .rst_ni, .en_i, .line_end_i(line_end),
    .ob_top_i, .ob_bot_i, .shut_line_i,
    .row_o(row), .field_o(field), .shut_hit_o(shut_hit), .region_o(row_rgn)
  );

  assign first_col = (col == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h1_o <= 1'b0; h2_o <= 1'b0; rg_o <= 1'b0; ds1_o <= 1'b0; ds2_o <= 1'b0;
      region_o <= REG_NONE; line_start_o <= 1'b0; field_start_o <= 1'b0;
      shutter_o <= 1'b0; col_o <= '0; line_o <= '0; field_o <= '0;
    end else begin
      h1_o          <= en_i && h1_c;
      h2_o          <= en_i && !h1_c;
      rg_o          <= en_i && rg_c;
      ds1_o         <= en_i && ds1_c;
      ds2_o         <= en_i && ds2_c;
      region_o      <= en_i ? merge_region(col_rgn, row_rgn) : REG_NONE;
      line_start_o  <= en_i && first_col;
      field_start_o <= en_i && first_col && (row == '0);
      shutter_o     <= en_i && first_col && shut_hit;
      col_o         <= en_i ? col : '0;
      line_o        <= en_i ? row : '0;
      field_o       <= field;
    end
  end

  a_r1_h1_two_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(h1_o) && en_i) |=> h1_o);
  a_r2_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ds1_o && ds2_o));
  a_r2_clamp_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ds1_o) |-> rg_o);
  a_r5_field_in_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_start_o |-> line_start_o);
  a_r6_shutter_at_line_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutter_o |-> line_start_o);
  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(h1_o || h2_o || rg_o || ds1_o || ds2_o || line_start_o || shutter_o));
endmodule

// File: tb/ccd_htiming_gen_test.sv
module ccd_htiming_gen_test;
  localparam int OBL = 2, ACT = 6, OBT = 3, HB = 2, OB_W = 3, ACTR = 3, FW = 4;
  localparam int SLOTS = 1 + OBL + ACT + OBT;
  localparam int LTOT  = SLOTS + HB;
  localparam int COL_W = $clog2(LTOT);
  localparam int ROW_W = $clog2(2 + ACTR + 2 * ((1 << OB_W) - 1));

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [OB_W-1:0] ob_top = 3'd1, ob_bot = 3'd1;
  logic [ROW_W-1:0] shut_line = ROW_W'(3);
  logic h1, h2, rg, ds1, ds2, ls, fs, sh;
  logic [1:0] rgn;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] line;
  logic [FW-1:0] fld;

  ccd_htiming_gen #(
    .OB_LEAD(OBL), .ACT_COLS(ACT), .OB_TRAIL(OBT), .HBLANK(HB),
    .ACT_ROWS(ACTR), .OB_W(OB_W), .FIELD_W(FW),
    .OB_TOP_RST(1), .OB_BOT_RST(1), .SHUT_RST(3)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .ob_top_i(ob_top), .ob_bot_i(ob_bot),
    .shut_line_i(shut_line), .h1_o(h1), .h2_o(h2), .rg_o(rg), .ds1_o(ds1),
    .ds2_o(ds2), .region_o(rgn), .line_start_o(ls), .field_start_o(fs),
    .shutter_o(sh), .col_o(col), .line_o(line), .field_o(fld)
  );

  always #2 clk = ~clk;

  typedef struct {
    int h1, h2, rg, ds1, ds2, rgn, ls, fs, sh, col, line, fld;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0, cycles = 0;
  string phase = "R10 reset";
  int m_tick = 0, m_col = 0, m_row = 0, m_fld = 0, m_started = 0;
  int s_top = 1, s_bot = 1, s_shut = 3;
  int sh_count = 0, full_field = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] act=%0d exp=%0d at cycle %0d", tag, phase, act, exp, cycles);
    end
  endtask

  function automatic int col_class(int c);
    if (c < 1) return 1;
    if (c < 1 + OBL) return 2;
    if (c < 1 + OBL + ACT) return 3;
    if (c < SLOTS) return 2;
    return 0;
  endfunction

  function automatic int row_class(int r);
    if (r < 2) return 1;
    if (r < 2 + s_top) return 2;
    if (r < 2 + s_top + ACTR) return 3;
    return 2;
  endfunction

  // driver side of the scoreboard: reference model pushes what each edge must produce
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_tick = 0; m_col = 0; m_row = 0; m_fld = 0; m_started = 0;
      s_top = 1; s_bot = 1; s_shut = 3;
    end else begin
      exp_t e;
      e = '{default: 0};
      e.fld = m_fld;
      if (en) begin
        int cc, rc;
        cc = col_class(m_col);
        rc = row_class(m_row);
        e.h1  = (m_tick < 2);
        e.h2  = (m_tick >= 2);
        e.rg  = (m_tick < 2);
        e.ds1 = (m_tick == 1 || m_tick == 2);
        e.ds2 = (m_tick == 3 || (m_tick == 0 && m_started == 1));
        if (cc == 0) e.rgn = 0;
        else if (cc == 1 || rc == 1) e.rgn = 1;
        else if (cc == 2 || rc == 2) e.rgn = 2;
        else e.rgn = 3;
        e.ls = (m_col == 0);
        e.fs = (m_col == 0 && m_row == 0);
        e.sh = (m_col == 0 && m_row == s_shut);
        e.col = m_col;
        e.line = m_row;
      end
      q.push_back(e);
      if (!en) begin
        m_tick = 0; m_col = 0; m_row = 0; m_started = 0;
        s_top = int'(ob_top); s_bot = int'(ob_bot); s_shut = int'(shut_line);
      end else begin
        if (m_tick == 3) begin
          m_started = 1;
          if (m_col == LTOT - 1) begin
            m_col = 0;
            if (m_row == 2 + s_top + ACTR + s_bot - 1) begin
              m_row = 0;
              m_fld = (m_fld + 1) % (1 << FW);
              s_top = int'(ob_top); s_bot = int'(ob_bot); s_shut = int'(shut_line);
            end else m_row++;
          end else m_col++;
        end
        m_tick = (m_tick + 1) % 4;
      end
    end
  end

  // monitor side: compare away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R10 h1", int'(h1), 0); chk("R10 ds2", int'(ds2), 0);
      chk("R10 region", int'(rgn), 0); chk("R10 field", int'(fld), 0);
    end else if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R1 h1", int'(h1), e.h1);
      chk("R1 h2", int'(h2), e.h2);
      chk("R2 rg", int'(rg), e.rg);
      chk("R2 ds1", int'(ds1), e.ds1);
      chk("R2 ds2", int'(ds2), e.ds2);
      chk("R3 R4 region", int'(rgn), e.rgn);
      chk("R5 line_start", int'(ls), e.ls);
      chk("R5 field_start", int'(fs), e.fs);
      chk("R6 shutter", int'(sh), e.sh);
      chk("R9 col", int'(col), e.col);
      chk("R9 line", int'(line), e.line);
      chk("R9 field", int'(fld), e.fld);
      // R6: one shutter pulse per complete field, counted at the start of the next
      if (fs && h1 && !h2 && rg && !ds1) begin
        if (full_field) chk("R6 pulses per field", sh_count, 1);
        full_field = 1;
        sh_count = 0;
      end
      if (sh && h1 && rg && !ds1) sh_count++;
    end
    if (!en) full_field = 0;
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  localparam int FIELD1 = (2 + 1 + ACTR + 1) * LTOT * 4;

  initial begin
    run(4);
    rst_n = 1'b1;
    phase = "R8 idle";
    run(6);
    phase = "R1 R2 first field";
    en = 1'b1;
    run(FIELD1 + FIELD1 / 2);
    phase = "R7 mid-field change";
    ob_top = 3'd2; ob_bot = 3'd0; shut_line = ROW_W'(0);
    run(3 * FIELD1);
    phase = "R8 disable mid-line";
    en = 1'b0;
    run(10);
    shut_line = ROW_W'(5);
    run(3);
    phase = "R8 R7 restart";
    en = 1'b1;
    run(3 * FIELD1);
    phase = "R8 final idle";
    en = 1'b0;
    run(8);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired R1 act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule